// File: doc/BRIEF.md
# Shadowed Nonvolatile Pin Register Core

This block holds the registers and memory behind a nine-pin open-drain I/O expander. A byte-wide slave port supplies address, write data, write and read strobes and a one-cycle pulse that marks the end of a transfer. The block returns an acknowledge and read data. Low addresses map a user memory that is nonvolatile only. A small upper window holds per-pin pullup enables, per-pin drive controls, a volatile configuration byte and read-only pin levels.

Pullup and drive values live in shadow flops that drive the pins directly. Behind each shadow flop sits a nonvolatile copy. Bit 0 of the configuration byte selects how a write is handled:
- Clear: the write is staged for the nonvolatile copy. The staged values are committed when the end-of-transfer pulse arrives, which starts a write-cycle timer.
- Set: only the shadow changes. No write cycle starts and the cell does not wear.

After power-up reset the shadows reload from the nonvolatile copy, so the pins come up in their programmed state without any host action. The nonvolatile model is brought to its factory image by a separate initialisation input.

Top module: `nvio_regcore`

## Requirements
- R1: Addresses 00h up to MEM_DEPTH-1 read back the bytes last written. Their contents survive a power-up reset (rst_n), and a write to them marks a pending commit.
- R2: Pullup enables sit at F0h (pins 0..7 in bits 0..7) and F1h (pin 8 in bit 0). Drive controls sit at F2h/F3h with the same mapping. A control bit of 0 drives the pin low and 1 releases it. Written values reach pin_drive_low and pin_pull_en in the cycle after the write, and the outputs are otherwise steady.
- R3: The configuration byte is at F4h and only bit 0 (shadow-only mode) is stored. It reads 00h after power-up reset, and its upper bits read 0.
- R4: With shadow-only mode clear, pullup and control writes become nonvolatile at the next end-of-transfer pulse. A later power-up reset restores them.
- R5: With shadow-only mode set, pullup and control writes change the pins at once but leave the nonvolatile copy untouched. A power-up reset therefore restores the earlier values.
- R6: A write that is not followed by an end-of-transfer pulse before power-up reset is never committed.
- R7: An end-of-transfer pulse with a pending commit raises busy in the next cycle for exactly TWR_CYCLES cycles. A pulse with nothing pending leaves busy low.
- R8: While busy, reads and writes are not acknowledged, writes are dropped and read data is 00h.
- R9: F8h (pins 0..7) and F9h (pin 8 in bit 0) return pin_in after a two-flop synchronizer, regardless of drive state.
- R10: Writes to unmapped or read-only addresses change nothing. Reads of unmapped addresses return 00h.
- R11: After rst_n is released, busy is high for one recall cycle. The outputs then equal the nonvolatile copy, which nv_init_n sets to PU_INIT and CTL_INIT.
- R12: An accepted access is acknowledged in the cycle after its strobe, with read data valid in that same cycle. Read data is 00h whenever there is no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_init_n | input | 1 | Active-low load of the factory image into the nonvolatile model |
| rst_n | input | 1 | Active-low power-up reset |
| bus_addr | input | 8 | Register/memory address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_stop | input | 1 | End-of-transfer pulse |
| bus_ack | output | 1 | Access accepted, one cycle after strobe |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| busy | output | 1 | Recall or nonvolatile write cycle in progress |
| pin_in | input | 9 | Sampled pin levels |
| pin_drive_low | output | 9 | Per-pin pull-down enable |
| pin_pull_en | output | 9 | Per-pin internal pullup enable |

## Verification
The bench builds the core with TWR_CYCLES set to 20, so the busy window can be counted cycle by cycle and several commits fit into a short run. It also builds it with a non-trivial factory image (CTL_INIT 155h, PU_INIT 0C3h). That image makes the first recall visible on the pins and distinguishes recalled values from reset defaults. Repeated power-up resets are applied between write sequences to separate committed, staged and shadow-only values.

// File: rtl/nvio_pkg.sv
package nvio_pkg;
  localparam int NPINS = 9;
  typedef logic [NPINS-1:0] pinvec_t;

  localparam logic [7:0] A_PU_LO  = 8'hF0;
  localparam logic [7:0] A_PU_HI  = 8'hF1;
  localparam logic [7:0] A_CTL_LO = 8'hF2;
  localparam logic [7:0] A_CTL_HI = 8'hF3;
  localparam logic [7:0] A_CFG    = 8'hF4;
  localparam logic [7:0] A_ST_LO  = 8'hF8;
  localparam logic [7:0] A_ST_HI  = 8'hF9;

  typedef enum logic [3:0] {
    RG_NONE, RG_MEM, RG_PU_LO, RG_PU_HI, RG_CTL_LO, RG_CTL_HI,
    RG_CFG, RG_ST_LO, RG_ST_HI
  } region_t;

  function automatic region_t decode(input logic [7:0] a, input int depth);
    if (int'(a) < depth) return RG_MEM;
    case (a)
      A_PU_LO:  return RG_PU_LO;
      A_PU_HI:  return RG_PU_HI;
      A_CTL_LO: return RG_CTL_LO;
      A_CTL_HI: return RG_CTL_HI;
      A_CFG:    return RG_CFG;
      A_ST_LO:  return RG_ST_LO;
      A_ST_HI:  return RG_ST_HI;
      default:  return RG_NONE;
    endcase
  endfunction

  function automatic logic [7:0] lo_byte(input pinvec_t v);
    return v[7:0];
  endfunction

  function automatic logic [7:0] hi_byte(input pinvec_t v);
    return {7'b0, v[8]};
  endfunction

  function automatic logic is_pinreg(input region_t r);
    return (r == RG_PU_LO) || (r == RG_PU_HI) || (r == RG_CTL_LO) || (r == RG_CTL_HI);
  endfunction
endpackage

// File: rtl/nvio_sync.sv
module nvio_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nvio_wr_timer.sv
module nvio_wr_timer #(
  parameter int TWR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(TWR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (start && !busy)  cnt <= CW'(TWR_CYCLES);
    else if (cnt != '0)       cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  // R7: a start from idle opens the busy window on the next cycle
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/nvio_usermem.sv
module nvio_usermem #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     nv_init_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [7:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [7:0]               rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge nv_init_n) begin
    if (!nv_init_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvio_regcore.sv
module nvio_regcore
  import nvio_pkg::*;
#(
  parameter int      MEM_DEPTH  = 64,
  parameter int      TWR_CYCLES = 1000,
  parameter pinvec_t PU_INIT    = '0,
  parameter pinvec_t CTL_INIT   = '1
) (
  input  logic       clk,
  input  logic       nv_init_n,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_stop,
  output logic       bus_ack,
  output logic [7:0] bus_rdata,
  output logic       busy,
  input  logic [8:0] pin_in,
  output logic [8:0] pin_drive_low,
  output logic [8:0] pin_pull_en
);
  localparam int AW = $clog2(MEM_DEPTH);

  pinvec_t sh_pu, sh_ctl, pend_pu, pend_ctl, nv_pu, nv_ctl, pin_sync;
  logic    see, recall_done, nv_dirty, tmr_busy;
  logic    wr_ok, rd_ok, commit, mem_we;
  logic [7:0] mem_q, rd_mux;
  region_t rg;

  assign rg     = decode(bus_addr, MEM_DEPTH);
  assign busy   = tmr_busy | ~recall_done;
  assign wr_ok  = bus_wr & ~busy;
  assign rd_ok  = bus_rd & ~busy;
  assign commit = bus_stop & ~busy & nv_dirty;
  assign mem_we = wr_ok && (rg == RG_MEM);

  nvio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  nvio_wr_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit), .busy(tmr_busy)
  );

  nvio_usermem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .nv_init_n(nv_init_n), .we(mem_we),
    .waddr(bus_addr[AW-1:0]), .wdata(bus_wdata),
    .raddr(bus_addr[AW-1:0]), .rdata(mem_q)
  );

  always_comb begin
    case (rg)
      RG_MEM:    rd_mux = mem_q;
      RG_PU_LO:  rd_mux = lo_byte(sh_pu);
      RG_PU_HI:  rd_mux = hi_byte(sh_pu);
      RG_CTL_LO: rd_mux = lo_byte(sh_ctl);
      RG_CTL_HI: rd_mux = hi_byte(sh_ctl);
      RG_CFG:    rd_mux = {7'b0, see};
      RG_ST_LO:  rd_mux = lo_byte(pin_sync);
      RG_ST_HI:  rd_mux = hi_byte(pin_sync);
      default:   rd_mux = 8'h00;
    endcase
  end

  // nonvolatile copy of the pin registers: survives power-up reset
  always_ff @(posedge clk or negedge nv_init_n) begin
    if (!nv_init_n) begin
      nv_pu  <= PU_INIT;
      nv_ctl <= CTL_INIT;
    end else if (commit) begin
      nv_pu  <= pend_pu;
      nv_ctl <= pend_ctl;
    end
  end

  // volatile state: shadows, staging, configuration, bus response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_done <= 1'b0;
      see         <= 1'b0;
      sh_pu       <= '0;
      sh_ctl      <= '1;
      pend_pu     <= '0;
      pend_ctl    <= '1;
      nv_dirty    <= 1'b0;
      bus_ack     <= 1'b0;
      bus_rdata   <= '0;
    end else if (!recall_done) begin
      recall_done <= 1'b1;
      sh_pu       <= nv_pu;
      sh_ctl      <= nv_ctl;
      pend_pu     <= nv_pu;
      pend_ctl    <= nv_ctl;
      bus_ack     <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      bus_ack   <= wr_ok | rd_ok;
      bus_rdata <= rd_ok ? rd_mux : 8'h00;
      if (commit) nv_dirty <= 1'b0;
      if (wr_ok) begin
        case (rg)
          RG_MEM: nv_dirty <= 1'b1;
          RG_PU_LO: begin
            sh_pu[7:0] <= bus_wdata;
            if (!see) begin pend_pu[7:0] <= bus_wdata; nv_dirty <= 1'b1; end
          end
          RG_PU_HI: begin
            sh_pu[8] <= bus_wdata[0];
            if (!see) begin pend_pu[8] <= bus_wdata[0]; nv_dirty <= 1'b1; end
          end
          RG_CTL_LO: begin
            sh_ctl[7:0] <= bus_wdata;
            if (!see) begin pend_ctl[7:0] <= bus_wdata; nv_dirty <= 1'b1; end
          end
          RG_CTL_HI: begin
            sh_ctl[8] <= bus_wdata[0];
            if (!see) begin pend_ctl[8] <= bus_wdata[0]; nv_dirty <= 1'b1; end
          end
          RG_CFG:  see <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  assign pin_drive_low = ~sh_ctl;
  assign pin_pull_en   = sh_pu;

  // R8: no acknowledge for a strobe seen while busy
  p_refuse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (bus_wr || bus_rd)) |=> !bus_ack);
  // R12: read data is zero whenever there is no acknowledge
  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == 8'h00));
  // R5: shadow-only writes leave the nonvolatile copy unchanged
  p_shadow_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && see && is_pinreg(rg) && !nv_dirty) |=> ($stable(nv_ctl) && $stable(nv_pu)));
  // R2: pin outputs move only after an accepted write
  p_pins_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_done && !wr_ok) |=> ($stable(pin_drive_low) && $stable(pin_pull_en)));
  // R11: at the end of recall the pins reflect the nonvolatile copy
  p_recall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_done) |-> ((pin_drive_low == ~nv_ctl) && (pin_pull_en == nv_pu)));
  // R7: a stop with nothing pending does not start a write cycle
  p_clean_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && !busy && !nv_dirty && !wr_ok) |=> !busy);
endmodule

// File: tb/nvio_regcore_tb.sv
module nvio_regcore_tb;
  logic clk = 1'b0;
  logic nv_init_n = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_stop = 1'b0;
  logic bus_ack, busy;
  logic [7:0] bus_rdata;
  logic [8:0] pin_in = '0, pin_drive_low, pin_pull_en;
  int checks = 0, fails = 0;

  localparam int TWR = 20;

  always #10 clk = ~clk;

  nvio_regcore #(.MEM_DEPTH(64), .TWR_CYCLES(TWR), .PU_INIT(9'h0C3), .CTL_INIT(9'h155)) u_dut (
    .clk(clk), .nv_init_n(nv_init_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_stop(bus_stop),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .pin_in(pin_in),
    .pin_drive_low(pin_drive_low), .pin_pull_en(pin_pull_en)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic exp_ack, input string tag);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk(tag, 16'(bus_ack), 16'(exp_ack));
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input logic exp_ack, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk({tag, " ack"}, 16'(bus_ack), 16'(exp_ack));
    chk({tag, " data"}, 16'(bus_rdata), 16'(exp));
  endtask

  task automatic stop_pulse();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic power_cycle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 recall busy", 16'(busy), 16'd1);
    @(negedge clk);
    chk("R11 recall done", 16'(busy), 16'd0);
  endtask

  task automatic t_powerup();
    repeat (3) @(negedge clk);
    nv_init_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R11 drive after first recall", 16'(pin_drive_low), 16'h0AA);
    chk("R11 pullup after first recall", 16'(pin_pull_en), 16'h0C3);
    rd(8'hF4, 8'h00, 1'b1, "R3 cfg reset");
    rd(8'hF2, 8'h55, 1'b1, "R12 ctl lo read");
  endtask

  task automatic t_usermem();
    int n;
    wr(8'h00, 8'hA5, 1'b1, "R1 wr 00");
    wr(8'h3F, 8'h3C, 1'b1, "R1 wr 3F");
    stop_pulse();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R7 busy length", 16'(n), 16'(TWR));
    stop_pulse();
    chk("R7 clean stop no busy", 16'(busy), 16'd0);
    power_cycle();
    rd(8'h00, 8'hA5, 1'b1, "R1 rd 00 after reset");
    rd(8'h3F, 8'h3C, 1'b1, "R1 rd 3F after reset");
  endtask

  task automatic t_refuse();
    wr(8'h01, 8'h11, 1'b1, "R1 wr 01");
    stop_pulse();
    rd(8'h00, 8'h00, 1'b0, "R8 read while busy");
    wr(8'hF2, 8'h00, 1'b0, "R8 write while busy");
    wait_idle();
    rd(8'hF2, 8'h55, 1'b1, "R8 dropped write");
    rd(8'h01, 8'h11, 1'b1, "R1 rd 01");
  endtask

  task automatic t_commit();
    wr(8'hF2, 8'h0F, 1'b1, "R2 wr ctl lo");
    wr(8'hF3, 8'h01, 1'b1, "R2 wr ctl hi");
    wr(8'hF0, 8'hF0, 1'b1, "R2 wr pu lo");
    wr(8'hF1, 8'h00, 1'b1, "R2 wr pu hi");
    chk("R2 drive map", 16'(pin_drive_low), 16'h0F0);
    chk("R2 pullup map", 16'(pin_pull_en), 16'h0F0);
    stop_pulse();
    chk("R7 busy after commit", 16'(busy), 16'd1);
    wait_idle();
    power_cycle();
    chk("R4 drive recalled", 16'(pin_drive_low), 16'h0F0);
    chk("R4 pullup recalled", 16'(pin_pull_en), 16'h0F0);
    rd(8'hF3, 8'h01, 1'b1, "R4 ctl hi recalled");
  endtask

  task automatic t_shadow();
    wr(8'hF4, 8'h01, 1'b1, "R3 set shadow mode");
    rd(8'hF4, 8'h01, 1'b1, "R3 cfg readback");
    wr(8'hF2, 8'hFF, 1'b1, "R5 wr ctl lo");
    wr(8'hF3, 8'h00, 1'b1, "R5 wr ctl hi");
    chk("R5 drive immediate", 16'(pin_drive_low), 16'h100);
    stop_pulse();
    chk("R5 no write cycle", 16'(busy), 16'd0);
    power_cycle();
    chk("R5 drive reverted", 16'(pin_drive_low), 16'h0F0);
    rd(8'hF4, 8'h00, 1'b1, "R3 cfg cleared by reset");
  endtask

  task automatic t_nostop();
    wr(8'hF2, 8'h00, 1'b1, "R6 wr ctl lo");
    chk("R6 drive immediate", 16'(pin_drive_low), 16'h0FF);
    power_cycle();
    chk("R6 uncommitted lost", 16'(pin_drive_low), 16'h0F0);
  endtask

  task automatic t_status();
    pin_in = 9'h1A3;
    repeat (3) @(negedge clk);
    rd(8'hF8, 8'hA3, 1'b1, "R9 status lo");
    rd(8'hF9, 8'h01, 1'b1, "R9 status hi");
    pin_in = 9'h05A;
    repeat (3) @(negedge clk);
    rd(8'hF8, 8'h5A, 1'b1, "R9 status lo 2");
    rd(8'hF9, 8'h00, 1'b1, "R9 status hi 2");
  endtask

  task automatic t_unmapped();
    wr(8'hF8, 8'h00, 1'b1, "R10 wr status");
    repeat (2) @(negedge clk);
    rd(8'hF8, 8'h5A, 1'b1, "R10 status unchanged");
    wr(8'h50, 8'h77, 1'b1, "R10 wr unmapped");
    rd(8'h50, 8'h00, 1'b1, "R10 rd unmapped");
    stop_pulse();
    chk("R10 unmapped no commit", 16'(busy), 16'd0);
    wr(8'hF4, 8'hFE, 1'b1, "R3 wr cfg upper");
    rd(8'hF4, 8'h00, 1'b1, "R3 cfg upper zero");
    chk("R10 pins untouched", 16'(pin_drive_low), 16'h0F0);
  endtask

  initial begin
    t_powerup();
    t_usermem();
    t_refuse();
    t_commit();
    t_shadow();
    t_nostop();
    t_status();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule